// File: doc/BRIEF.md
# Three-bit Suffix Mealy Detector

This block watches a serial stream that delivers one bit per clock. In the same cycle that a bit arrives, it raises its output when that bit completes any of the three-bit suffixes `011`, `101` or `110`. The output is a Mealy output: it depends on the stored state and on the live input bit, so the detection is visible before the clock edge that consumes the bit. Only six states are needed, and they sit in a three-bit register. The code of each state carries meaning. Bit 0 is set when the last bit consumed was a zero. Bit 2 is set once at least two bits have been seen and the history can complete a match.

The register can be built in two ways. By default each state bit behaves as a J-K stage, with set and clear terms derived for that bit. A compile-time parameter replaces this with a plain next-state form, and both forms follow the same state sequence. The codes `011` and `111` are not used. If the register ever holds one of them, the block returns to the start code on the next clock and keeps the output low meanwhile. The state register is visible on a port, so a neighbouring block can watch progress.

Top module: `trisuffix_detect`

## Requirements
- R1: While `rst` is high, `hit` is 0 for any `bit_in`, and the clock edge that samples `rst` high loads `state_out` with 3'b000.
- R2: After reset, `hit` is 1 in a cycle exactly when the last three bits, the current `bit_in` included, read `011`, `101` or `110` oldest first, and at least two bits have already been consumed since reset. In every other cycle `hit` is 0.
- R3: For the first and second bits after reset, `hit` is 0 whatever their values.
- R4: From reset, the bit stream 0,1,1,0,1,1,1,0,0 gives `hit` 0,0,1,1,1,1,0,1,0.
- R5: The state codes are: start 000, last-bit-zero 001, single one 010, history ending 01 = 100, history ending 10 = 101, history ending 11 = 110. For `bit_in` 0 and 1 respectively, the next code and `hit` from each state are: 000 gives 001/0 and 010/0; 001 gives 001/0 and 100/0; 010 gives 101/0 and 110/0; 100 gives 101/0 and 110/1; 101 gives 001/0 and 100/1; 110 gives 101/1 and 110/0.
- R6: After each consumed bit that leaves a legal code, `state_out[0]` is the inverse of that bit.
- R7: The J-K form (`USE_JK`=1) and the plain next-state form (`USE_JK`=0) produce identical `state_out` and `hit` sequences for the same input.
- R8: When the register holds 011 or 111, `hit` is 0 in that cycle and the next clock loads 000, in both forms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial input bit, one per clock |
| hit | output | 1 | Mealy match flag for the current bit |
| state_out | output | 3 | Current state register contents |

## Verification
The bench walks every legal state with both input values and compares the next code and `hit`. A swapped J or K term would show up as a wrong code after a hold or toggle case, such as 110 staying put on a one. The warm-up window is probed separately, because a design that ignores the bit count would flag `011` patterns split across a reset. The unused codes are injected into the next-state path of each form, and a design without recovery would stay stuck or, at 111 with a zero input, raise a false `hit`. A long random stream drives both forms side by side against a shift-history model, so any difference between the J-K and plain equations shows up as a state mismatch.

// File: rtl/trisfx_pkg.sv
package trisfx_pkg;
  localparam int ST_W = 3;
  typedef logic [ST_W-1:0] st_t;

  localparam st_t ST_IDLE = 3'b000;
  localparam st_t ST_ZERO = 3'b001;
  localparam st_t ST_ONE  = 3'b010;
  localparam st_t ST_B01  = 3'b100;
  localparam st_t ST_B10  = 3'b101;
  localparam st_t ST_B11  = 3'b110;

  // one J-K stage: hold, set, clear or toggle
  function automatic logic jk_bit(input logic q, input logic j, input logic k);
    return (j & ~q) | (~k & q);
  endfunction

  // codes with both low bits set are never used
  function automatic logic code_ok(input st_t st);
    return ~(st[1] & st[0]);
  endfunction

  // Mealy output for a legal state
  function automatic logic hit_of(input st_t st, input logic b);
    return st[2] & (st[1] ^ b);
  endfunction
endpackage

// File: rtl/trisfx_jk_cell.sv
module trisfx_jk_cell (
  input  logic q,
  input  logic j,
  input  logic k,
  output logic q_nxt
);
  import trisfx_pkg::*;
  assign q_nxt = jk_bit(q, j, k);
endmodule

// File: rtl/trisfx_jk_path.sv
module trisfx_jk_path
  import trisfx_pkg::*;
(
  input  st_t  cur,
  input  logic b,
  output st_t  j_vec,
  output st_t  k_vec,
  output st_t  nxt
);
  always_comb begin
    j_vec[2] = cur[1] | (cur[0] & b);
    k_vec[2] = cur[0] & ~b;
    j_vec[1] = ~cur[0] & b;
    k_vec[1] = ~b;
    j_vec[0] = ~b;
    k_vec[0] = b;
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_stage
    trisfx_jk_cell u_cell (
      .q    (cur[i]),
      .j    (j_vec[i]),
      .k    (k_vec[i]),
      .q_nxt(nxt[i])
    );
  end
endmodule

// File: rtl/trisfx_d_path.sv
module trisfx_d_path
  import trisfx_pkg::*;
(
  input  st_t  cur,
  input  logic b,
  output st_t  nxt
);
  always_comb begin
    nxt[2] = (~cur[0] | b) & (cur[2] | cur[1] | cur[0]);
    nxt[1] = ~cur[0] & b;
    nxt[0] = ~b;
  end
endmodule

// File: rtl/trisuffix_detect.sv
module trisuffix_detect
  import trisfx_pkg::*;
#(
  parameter bit USE_JK = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_in,
  output logic            hit,
  output logic [ST_W-1:0] state_out
);
  st_t  state_q;
  st_t  raw_next;
  st_t  state_d;
  logic code_bad;

  assign code_bad = ~code_ok(state_q);

  if (USE_JK) begin : g_jk
    st_t j_w, k_w;
    trisfx_jk_path u_path (
      .cur  (state_q),
      .b    (bit_in),
      .j_vec(j_w),
      .k_vec(k_w),
      .nxt  (raw_next)
    );
  end else begin : g_d
    trisfx_d_path u_path (
      .cur(state_q),
      .b  (bit_in),
      .nxt(raw_next)
    );
  end

  always_comb begin
    if (rst || code_bad) state_d = ST_IDLE;
    else                 state_d = raw_next;
  end

  always_ff @(posedge clk) state_q <= state_d;

  assign hit       = ~rst & ~code_bad & hit_of(state_q, bit_in);
  assign state_out = state_q;
endmodule

// File: rtl/trisfx_chk.sv
module trisfx_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_in,
  input logic       hit,
  input logic [2:0] state,
  input logic       code_bad
);
  // R1
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> state == 3'b000);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |-> !hit);
  // R8
  p_recover_r8: assert property (@(posedge clk) disable iff (rst)
    code_bad |=> state == 3'b000);
  p_bad_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    code_bad |-> !hit);
  // R6
  p_track_r6: assert property (@(posedge clk) disable iff (rst)
    !code_bad |=> state[0] == !$past(bit_in));
  // R3: a match needs a state reached after two bits
  p_hist_r3: assert property (@(posedge clk) disable iff (rst)
    hit |-> state[2]);
endmodule

bind trisuffix_detect trisfx_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_in  (bit_in),
  .hit     (hit),
  .state   (state_out),
  .code_bad(code_bad)
);

// File: tb/sim_trisuffix_detect.sv
module sim_trisuffix_detect;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  wire        z0, z1;
  wire  [2:0] s0w, s1w;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  trisuffix_detect #(.USE_JK(1'b1)) u0 (
    .clk(clk), .rst(rst), .bit_in(x), .hit(z0), .state_out(s0w));
  trisuffix_detect #(.USE_JK(1'b0)) u1 (
    .clk(clk), .rst(rst), .bit_in(x), .hit(z1), .state_out(s1w));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic step(input logic xb, output logic zz, output logic [2:0] st);
    x = xb;
    #(PER/4);
    zz = z0;
    @(posedge clk); #1;
    st = s0w;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; x = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; x = 1'b1;
    #(PER/4);
    chk("R1 hit low in reset jk", {3'b0, z0}, 4'd0);
    chk("R1 hit low in reset d", {3'b0, z1}, 4'd0);
    @(posedge clk); #1;
    chk("R1 state after reset", {1'b0, s0w}, 4'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_example();
    logic [8:0] seq  = 9'b001110110; // bit i is stream position i
    logic [8:0] expz = 9'b010111100;
    logic zz; logic [2:0] st;
    do_reset();
    for (int i = 0; i < 9; i++) begin
      step(seq[i], zz, st);
      chk($sformatf("R4 example pos %0d", i), {3'b0, zz}, {3'b0, expz[i]});
    end
  endtask

  function automatic logic [2:0] code_of(input int s);
    case (s)
      0: return 3'b000; 1: return 3'b001; 2: return 3'b010;
      3: return 3'b100; 4: return 3'b101; default: return 3'b110;
    endcase
  endfunction

  task automatic t_table();
    logic zz; logic [2:0] st;
    logic [2:0] n0 [6] = '{3'b001, 3'b001, 3'b101, 3'b101, 3'b001, 3'b101};
    logic [2:0] n1 [6] = '{3'b010, 3'b100, 3'b110, 3'b110, 3'b100, 3'b110};
    logic       h0 [6] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    logic       h1 [6] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    for (int s = 0; s < 6; s++) begin
      for (int xb = 0; xb < 2; xb++) begin
        do_reset();
        case (s)
          1: step(1'b0, zz, st);
          2: step(1'b1, zz, st);
          3: begin step(1'b0, zz, st); step(1'b1, zz, st); end
          4: begin step(1'b1, zz, st); step(1'b0, zz, st); end
          5: begin step(1'b1, zz, st); step(1'b1, zz, st); end
          default: ;
        endcase
        if (xb == 0)
          chk($sformatf("R5 code of state %0d", s), {1'b0, s0w}, {1'b0, code_of(s)});
        step(xb[0], zz, st);
        chk($sformatf("R5 hit from %b x=%0d", code_of(s), xb), {3'b0, zz},
            {3'b0, (xb == 0) ? h0[s] : h1[s]});
        chk($sformatf("R5 next from %b x=%0d", code_of(s), xb), {1'b0, st},
            {1'b0, (xb == 0) ? n0[s] : n1[s]});
      end
    end
  endtask

  task automatic t_warmup();
    logic zz; logic [2:0] st;
    for (int p = 0; p < 4; p++) begin
      do_reset();
      step(p[1], zz, st);
      chk($sformatf("R3 first bit pattern %0d", p), {3'b0, zz}, 4'd0);
      step(p[0], zz, st);
      chk($sformatf("R3 second bit pattern %0d", p), {3'b0, zz}, 4'd0);
    end
  endtask

  task automatic t_random();
    logic [1:0] hist = 2'b00;
    int cnt = 0;
    logic xb, ez;
    logic [2:0] pat;
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      if (i == 1500) begin
        do_reset();
        cnt = 0; hist = 2'b00;
      end
      xb = 1'($urandom);
      pat = {hist, xb};
      ez = (cnt >= 2) && (pat == 3'b011 || pat == 3'b101 || pat == 3'b110);
      x = xb;
      #(PER/4);
      chk("R2 random hit", {3'b0, z0}, {3'b0, ez});
      chk("R7 hit jk vs d", {3'b0, z0}, {3'b0, z1});
      @(posedge clk); #1;
      chk("R7 state jk vs d", {1'b0, s0w}, {1'b0, s1w});
      chk("R6 low bit tracks inverse", {3'b0, s0w[0]}, {3'b0, ~xb});
      hist = {hist[0], xb};
      if (cnt < 2) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_illegal();
    logic [2:0] bad;
    for (int c = 0; c < 4; c++) begin
      bad = c[1] ? 3'b111 : 3'b011;
      // form J-K
      do_reset();
      force u0.state_d = bad;
      @(posedge clk); #1;
      release u0.state_d;
      x = c[0];
      #(PER/4);
      chk($sformatf("R8 jk hit at %b x=%0d", bad, c[0]), {3'b0, z0}, 4'd0);
      @(posedge clk); #1;
      chk($sformatf("R8 jk recover from %b", bad), {1'b0, s0w}, 4'd0);
      @(negedge clk);
      // plain form
      do_reset();
      force u1.state_d = bad;
      @(posedge clk); #1;
      release u1.state_d;
      x = c[0];
      #(PER/4);
      chk($sformatf("R8 d hit at %b x=%0d", bad, c[0]), {3'b0, z1}, 4'd0);
      @(posedge clk); #1;
      chk($sformatf("R8 d recover from %b", bad), {1'b0, s1w}, 4'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_example();
    t_table();
    t_warmup();
    t_illegal();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(PER * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule